// File: doc/BRIEF.md
# Shifted Mismatch Mask Generator

This block compares a DNA read with a reference segment of equal length and produces a set of per-base mismatch masks. It serves as the front end of an alignment pre-filter. Each base is held as a 2-bit code. Two bases are compared by XOR-ing their codes and OR-ing the two result bits, so every base position gives exactly one mask bit: 0 for a match and 1 for a mismatch.

Besides the direct comparison, the block compares the read displaced by every whole-base offset from one up to `EMAX`, in both directions, against the same reference. A displacement towards higher positions lines up bases that follow a deletion in the read. A displacement towards lower positions does the same for an insertion. All lanes are formed in parallel. Positions that a displacement leaves without a read base are reported as mismatches.

Later stages clean, merge and count the masks; those stages are not part of this block. A parameter selects between a purely combinational path and one output register stage.

Top module: `shift_mask_gen`

## Requirements
- R1: With read and reference identical, lane 0 (no displacement) is all zeros.
- R2: A mask bit is 1 exactly when the two 2-bit codes differ in either bit, and 0 when both bits agree.
- R3: `mask_bus` holds 2·EMAX+1 lanes of READ_LEN bits each. Lane j occupies bits [j·READ_LEN +: READ_LEN], and bit p of a lane belongs to base position p.
- R4: In lane k for 1 ≤ k ≤ EMAX, bit p compares read base p−k with reference base p.
- R5: In lane EMAX+k for 1 ≤ k ≤ EMAX, bit p compares read base p+k with reference base p.
- R6: A lane bit whose read base index falls outside 0..READ_LEN−1 is 1. These are the lowest k bits of lane k and the highest k bits of lane EMAX+k.
- R7: Lane order is fixed: lane 0 has no displacement, lanes 1..EMAX are displaced towards higher positions by 1..EMAX, and lanes EMAX+1..2·EMAX are displaced towards lower positions by 1..EMAX.
- R8: Base p sits at bits [2p+1:2p] of `read_seq` and `ref_seq`, coded A=00, C=01, G=10, T=11.
- R9: With REG_OUT=1, `mask_bus` shows the masks of the inputs present at the previous rising clock edge. While `rst_n` is low it reads all ones.
- R10: With REG_OUT=0, `mask_bus` follows the inputs in the same cycle, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| read_seq | input | 2·READ_LEN | Read bases, base p at bits [2p+1:2p] |
| ref_seq | input | 2·READ_LEN | Reference bases, same layout |
| mask_bus | output | (2·EMAX+1)·READ_LEN | All mismatch lanes, lane j at [j·READ_LEN +: READ_LEN] |

## Verification
The assertions assume that each input value is held for a whole clock period. In registered mode they assume that the output reflects the inputs captured one edge earlier. For that reason the checker holds its own sampled copy of the inputs and waits one cycle after reset before comparing. The bench keeps within these assumptions by changing `read_seq` and `ref_seq` only on falling edges and holding them for at least one full period. The identity and complement properties only fire when the stimulus happens to present those cases. The bench therefore applies both on purpose, alongside a sweep over all sixteen code pairs and reads that are displaced copies of the reference.

// File: rtl/mask_gen_pkg.sv
package mask_gen_pkg;

    typedef logic [1:0] base_code_t;

    localparam base_code_t BASE_A = 2'b00;
    localparam base_code_t BASE_C = 2'b01;
    localparam base_code_t BASE_G = 2'b10;
    localparam base_code_t BASE_T = 2'b11;

    // Signed displacement of lane j: 0, +1..+emax, then -1..-emax
    function automatic int lane_shift(input int j, input int emax);
        if (j == 0)
            return 0;
        else if (j <= emax)
            return j;
        else
            return -(j - emax);
    endfunction

endpackage

// File: rtl/base_cmp.sv
module base_cmp (
    input  logic [1:0] read_base,
    input  logic [1:0] ref_base,
    output logic       mismatch
);
    logic [1:0] diff;

    always_comb begin
        diff     = read_base ^ ref_base;
        mismatch = diff[1] | diff[0];
    end
endmodule

// File: rtl/mask_lane.sv
module mask_lane #(
    parameter int READ_LEN = 100,
    parameter int SHIFT    = 0
) (
    input  logic [2*READ_LEN-1:0] read_seq,
    input  logic [2*READ_LEN-1:0] ref_seq,
    output logic [READ_LEN-1:0]   lane_mask
);
    for (genvar p = 0; p < READ_LEN; p++) begin : g_pos
        localparam int SRC = p - SHIFT;
        if (SRC >= 0 && SRC < READ_LEN) begin : g_cmp
            base_cmp u_cmp (
                .read_base (read_seq[2*SRC +: 2]),
                .ref_base  (ref_seq[2*p +: 2]),
                .mismatch  (lane_mask[p])
            );
        end else begin : g_fill
            // no read base covers this position
            assign lane_mask[p] = 1'b1;
        end
    end
endmodule

// File: rtl/shift_mask_gen.sv
module shift_mask_gen
    import mask_gen_pkg::*;
#(
    parameter int READ_LEN = 100,
    parameter int EMAX     = 5,
    parameter bit REG_OUT  = 1'b1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [2*READ_LEN-1:0]               read_seq,
    input  logic [2*READ_LEN-1:0]               ref_seq,
    output logic [(2*EMAX+1)*READ_LEN-1:0]      mask_bus
);
    localparam int NUM_LANES = 2 * EMAX + 1;
    localparam int BUS_W     = NUM_LANES * READ_LEN;

    logic [BUS_W-1:0] lane_bus;

    for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
        mask_lane #(
            .READ_LEN (READ_LEN),
            .SHIFT    (lane_shift(j, EMAX))
        ) u_lane (
            .read_seq  (read_seq),
            .ref_seq   (ref_seq),
            .lane_mask (lane_bus[j*READ_LEN +: READ_LEN])
        );
    end

    if (REG_OUT) begin : g_reg
        typedef struct packed {
            logic [BUS_W-1:0] masks;
        } out_state_t;

        out_state_t state_d, state_q;

        always_comb begin
            state_d       = state_q;
            state_d.masks = lane_bus;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                state_q.masks <= '1;
            else
                state_q <= state_d;
        end

        assign mask_bus = state_q.masks;
    end else begin : g_comb
        assign mask_bus = lane_bus;
    end
endmodule

// File: rtl/mask_gen_chk.sv
module mask_gen_chk #(
    parameter int READ_LEN = 100,
    parameter int EMAX     = 5,
    parameter bit REG_OUT  = 1'b1
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [2*READ_LEN-1:0]          read_seq,
    input logic [2*READ_LEN-1:0]          ref_seq,
    input logic [(2*EMAX+1)*READ_LEN-1:0] mask_bus
);
    logic [2*READ_LEN-1:0] samp_read, samp_ref;
    logic [1:0]            age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            age_q <= '0;
        else if (age_q != 2'd3)
            age_q <= age_q + 2'd1;
    end

    if (REG_OUT) begin : g_samp_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                samp_read <= '0;
                samp_ref  <= '0;
            end else begin
                samp_read <= read_seq;
                samp_ref  <= ref_seq;
            end
        end
    end else begin : g_samp_comb
        assign samp_read = read_seq;
        assign samp_ref  = ref_seq;
    end

    logic live;
    assign live = REG_OUT ? (age_q >= 2'd1) : 1'b1;

    // R1
    identical_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && samp_read == samp_ref) |-> (mask_bus[READ_LEN-1:0] == '0));

    // R2
    complement_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && samp_read == ~samp_ref) |-> (mask_bus[READ_LEN-1:0] == '1));

    // R9
    steady_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && $stable(samp_read) && $stable(samp_ref)) |-> $stable(mask_bus));

    for (genvar k = 1; k <= EMAX; k++) begin : g_edge
        // R6
        low_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mask_bus[k*READ_LEN +: k] == '1);
        // R6
        high_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mask_bus[(EMAX+k)*READ_LEN + READ_LEN - k +: k] == '1);
    end
endmodule

bind shift_mask_gen mask_gen_chk #(
    .READ_LEN (READ_LEN),
    .EMAX     (EMAX),
    .REG_OUT  (REG_OUT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .read_seq (read_seq),
    .ref_seq  (ref_seq),
    .mask_bus (mask_bus)
);

// File: tb/shift_mask_gen_test.sv
module shift_mask_gen_test;
    localparam int M = 8;
    localparam int E = 2;
    localparam int N = 2 * E + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2*M-1:0] rd = '0;
    logic [2*M-1:0] rf = '0;
    logic [N*M-1:0] mq, mc;

    int errs = 0;
    int checks = 0;
    logic [31:0] seed = 32'h1357_2468;

    always #10 clk = ~clk;

    shift_mask_gen #(.READ_LEN(M), .EMAX(E), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .read_seq(rd), .ref_seq(rf), .mask_bus(mq));

    shift_mask_gen #(.READ_LEN(M), .EMAX(E), .REG_OUT(1'b0)) uut_comb (
        .clk(clk), .rst_n(rst_n), .read_seq(rd), .ref_seq(rf), .mask_bus(mc));

    function automatic int shift_of(input int j);
        if (j == 0) return 0;
        if (j <= E) return j;
        return -(j - E);
    endfunction

    // Expected lane j from R2, R4, R5, R6, R8
    function automatic logic [M-1:0] model(input logic [2*M-1:0] r, input logic [2*M-1:0] f, input int j);
        logic [M-1:0] m;
        for (int p = 0; p < M; p++) begin
            int src;
            src = p - shift_of(j);
            if (src < 0 || src >= M) m[p] = 1'b1;
            else m[p] = (r[2*src +: 2] != f[2*p +: 2]);
        end
        return m;
    endfunction

    function automatic logic [2*M-1:0] rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed[31:16];
    endfunction

    task automatic chk(input string tag, input logic [M-1:0] act, input logic [M-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic string lane_tag(input int j);
        if (j == 0) return "R1 R2 R3 R8";
        if (j <= E) return "R3 R4 R6 R7";
        return "R3 R5 R6 R7";
    endfunction

    task automatic run_vec(input logic [2*M-1:0] r, input logic [2*M-1:0] f);
        @(negedge clk);
        rd = r;
        rf = f;
        #1;
        for (int j = 0; j < N; j++)
            chk("R10 comb", mc[j*M +: M], model(r, f, j));
        @(negedge clk);
        for (int j = 0; j < N; j++)
            chk(lane_tag(j), mq[j*M +: M], model(r, f, j));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [2*M-1:0] r, f, prev_r;
        repeat (2) @(negedge clk);
        // R9: reset value
        for (int j = 0; j < N; j++) chk("R9 reset", mq[j*M +: M], '1);
        rst_n = 1'b1;

        // R1: identical inputs
        r = rnd();
        run_vec(r, r);
        // R2: complemented reference differs at every base
        run_vec(r, ~r);

        // R2 R8: every code pair at every position
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                run_vec({M{a[1:0]}}, {M{b[1:0]}});

        // R4 R6: reference equal to read displaced up by k
        for (int k = 1; k <= E; k++) begin
            r = rnd();
            f = rnd();
            for (int p = k; p < M; p++) f[2*p +: 2] = r[2*(p-k) +: 2];
            run_vec(r, f);
            chk("R4 R6 aligned", mq[k*M +: M], (M'(1) << k) - M'(1));
        end
        // R5 R6: reference equal to read displaced down by k
        for (int k = 1; k <= E; k++) begin
            r = rnd();
            f = rnd();
            for (int p = 0; p + k < M; p++) f[2*p +: 2] = r[2*(p+k) +: 2];
            run_vec(r, f);
            chk("R5 R6 aligned", mq[(E+k)*M +: M], ~((M'(1) << (M-k)) - M'(1)));
        end

        // R9: output holds old masks until the next rising edge
        prev_r = rnd();
        run_vec(prev_r, prev_r);
        @(negedge clk);
        rd = prev_r;
        rf = ~prev_r;
        #1;
        chk("R9 latency hold", mq[M-1:0], '0);
        @(negedge clk);
        chk("R9 latency update", mq[M-1:0], '1);

        // mixed random pairs
        for (int i = 0; i < 40; i++) begin
            r = rnd();
            f = (i % 2 == 0) ? rnd() : (r ^ (16'h1 << (i % (2*M))));
            run_vec(r, f);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule